// File: doc/BRIEF.md
# Two-Channel Autosweep Input Sequencer

This block selects which of two analog inputs a serial converter samples. The converter has a single active-low pin that serves as both chip select and frame sync. The sequencer counts serial clock rising edges while that pin is low. When the pin rises again, the length of the frame and whether its conversion finished decide the next channel. A complete frame swaps to the other input. A short frame of four to seven clocks returns the selection to channel 0. Any other frame leaves the selection unchanged. The analog switches themselves are outside this block.

Each conversion result leaves the device during the frame after the one in which it was sampled. The block therefore latches a tag when each frame opens. The tag holds the channel of the data now being shifted out and a flag that says whether that data is valid. A frame that closes before its conversion has finished aborts that conversion, and the block signals this with a one-cycle pulse. All inputs are taken as synchronous to the system clock `clk`. Frame edges and serial clock edges are found by comparing each input with its value from the previous cycle.

Top module: `sweep_seq`

## Requirements
- R1: While reset is asserted and directly after it, `ch_sel` is 0, `res_ch` is 0, and `res_valid` and `conv_abort` are both 0.
- R2: A frame that counts at least 16 serial clock rising edges and then receives a `conv_done` pulse before `cs_n` rises is complete. On the clock edge that first sees `cs_n` high, `ch_sel` inverts.
- R3: A frame that counts 4 to 7 serial clock rising edges, both limits included, sets `ch_sel` to 0 when `cs_n` rises, whatever its previous value. The result tagged at the next frame start is marked invalid.
- R4: A frame with fewer than 4 serial clock rising edges leaves `ch_sel` unchanged. The next result is marked invalid.
- R5: A frame with 8 or more serial clock rising edges that does not complete leaves `ch_sel` unchanged. The next result is marked invalid.
- R6: `ch_sel` changes only on the clock edge that detects `cs_n` rising. It stays stable during an active frame and between frames.
- R7: On the clock edge that detects `cs_n` falling, `res_ch` loads the channel that was selected during the previous frame, and `res_valid` loads 1 only if that frame was complete. Both then hold their values while `cs_n` stays low.
- R8: `conv_done` is ignored before the 16th serial clock of a frame and while `cs_n` is high. Such a pulse cannot make a frame complete.
- R9: When a frame with at least 16 serial clocks closes without completing, `conv_abort` is 1 for exactly one cycle, on the edge that detects `cs_n` rising. In every other case it stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Shared chip-select / frame-sync, active low |
| sclk | input | 1 | Serial clock from the host, sampled level |
| conv_done | input | 1 | One-cycle pulse: the running conversion has finished |
| ch_sel | output | 1 | Channel currently connected to the sampler (0 or 1) |
| res_ch | output | 1 | Channel the outgoing result was sampled from |
| res_valid | output | 1 | Outgoing result comes from a completed conversion |
| conv_abort | output | 1 | One-cycle pulse: a started conversion was cut short |

## Verification
The checker assumes several things about the inputs. `cs_n` and `sclk` are clean levels that are already synchronous to `clk`. Each level of `sclk` lasts at least one clock cycle. `conv_done` never arrives on the same cycle that `cs_n` rises. Reset is applied from time zero. The stimulus respects all of these. It changes inputs only on falling `clk` edges. It holds every `sclk` level for two cycles and keeps `cs_n` low for a cycle on each side of the clock burst. It places `conv_done` pulses one cycle wide while `sclk` is low and well before the frame closes.

// File: rtl/sweep_seq_pkg.sv
package sweep_seq_pkg;
  // Decision taken when a frame closes
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_HOME   = 2'd2
  } seq_act_e;
endpackage

// File: rtl/sweep_frame_track.sv
module sweep_frame_track #(
  parameter int FULL_CLKS = 16,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             conv_done,
  output logic             open_edge,
  output logic             close_edge,
  output logic [CNT_W-1:0] clk_count,
  output logic             done_seen
);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(FULL_CLKS);

  logic             cs_q, sclk_q;
  logic             sclk_rise;
  logic             cnt_full;
  logic [CNT_W-1:0] cnt_d;
  logic             done_d;
  logic             cnt_en, done_en;

  assign open_edge  = ~cs_n & cs_q;
  assign close_edge = cs_n & ~cs_q;
  assign sclk_rise  = sclk & ~sclk_q & ~cs_n;
  assign cnt_full   = (clk_count >= FULL_C);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = clk_count;
    if (open_edge) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (sclk_rise && !cnt_full) begin
      cnt_en = 1'b1;
      cnt_d  = clk_count + 1'b1;
    end
  end

  always_comb begin
    done_en = 1'b0;
    done_d  = done_seen;
    if (open_edge) begin
      done_en = 1'b1;
      done_d  = 1'b0;
    end else if (!cs_n && conv_done && cnt_full) begin
      done_en = 1'b1;
      done_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_count <= '0;
      done_seen <= 1'b0;
    end else begin
      if (cnt_en)  clk_count <= cnt_d;
      if (done_en) done_seen <= done_d;
    end
  end
endmodule

// File: rtl/sweep_judge.sv
module sweep_judge
  import sweep_seq_pkg::*;
#(
  parameter int SHORT_MIN = 4,
  parameter int SHORT_MAX = 7,
  parameter int FULL_CLKS = 16,
  parameter int CNT_W     = 5
) (
  input  logic [CNT_W-1:0] clk_count,
  input  logic             done_seen,
  output seq_act_e         act,
  output logic             abort_req
);
  localparam logic [CNT_W-1:0] LO_C   = CNT_W'(SHORT_MIN);
  localparam logic [CNT_W-1:0] HI_C   = CNT_W'(SHORT_MAX);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(FULL_CLKS);

  logic started, in_short;

  assign started  = (clk_count >= FULL_C);
  assign in_short = (clk_count >= LO_C) && (clk_count <= HI_C);

  always_comb begin
    act       = ACT_HOLD;
    abort_req = 1'b0;
    if (started && done_seen) begin
      act = ACT_TOGGLE;
    end else if (in_short) begin
      act = ACT_HOME;
    end else if (started) begin
      abort_req = 1'b1;
    end
  end
endmodule

// File: rtl/sweep_chan_state.sv
module sweep_chan_state
  import sweep_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     open_edge,
  input  logic     close_edge,
  input  seq_act_e act,
  input  logic     abort_req,
  output logic     ch_sel,
  output logic     res_ch,
  output logic     res_valid,
  output logic     conv_abort
);
  logic sel_d, pend_ch, pend_vld, pend_ch_d, pend_vld_d;
  logic tag_ch_d, tag_vld_d, abort_d;

  always_comb begin
    sel_d      = ch_sel;
    pend_ch_d  = pend_ch;
    pend_vld_d = pend_vld;
    if (close_edge) begin
      pend_ch_d  = ch_sel;
      pend_vld_d = (act == ACT_TOGGLE);
      unique case (act)
        ACT_TOGGLE: sel_d = ~ch_sel;
        ACT_HOME:   sel_d = 1'b0;
        default:    sel_d = ch_sel;
      endcase
    end
    tag_ch_d  = open_edge ? pend_ch  : res_ch;
    tag_vld_d = open_edge ? pend_vld : res_valid;
    abort_d   = close_edge & abort_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_sel     <= 1'b0;
      pend_ch    <= 1'b0;
      pend_vld   <= 1'b0;
      res_ch     <= 1'b0;
      res_valid  <= 1'b0;
      conv_abort <= 1'b0;
    end else begin
      if (close_edge) begin
        ch_sel   <= sel_d;
        pend_ch  <= pend_ch_d;
        pend_vld <= pend_vld_d;
      end
      if (open_edge) begin
        res_ch    <= tag_ch_d;
        res_valid <= tag_vld_d;
      end
      conv_abort <= abort_d;
    end
  end
endmodule

// File: rtl/sweep_seq.sv
module sweep_seq
  import sweep_seq_pkg::*;
#(
  parameter int SHORT_MIN = 4,
  parameter int SHORT_MAX = 7,
  parameter int FULL_CLKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic conv_done,
  output logic ch_sel,
  output logic res_ch,
  output logic res_valid,
  output logic conv_abort
);
  localparam int CNT_W = $clog2(FULL_CLKS + 1);

  logic             open_edge, close_edge, done_seen, abort_req;
  logic [CNT_W-1:0] clk_count;
  seq_act_e         act;

  sweep_frame_track #(.FULL_CLKS(FULL_CLKS), .CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .conv_done(conv_done),
    .open_edge(open_edge), .close_edge(close_edge),
    .clk_count(clk_count), .done_seen(done_seen)
  );

  sweep_judge #(.SHORT_MIN(SHORT_MIN), .SHORT_MAX(SHORT_MAX),
                .FULL_CLKS(FULL_CLKS), .CNT_W(CNT_W)) u_judge (
    .clk_count(clk_count), .done_seen(done_seen),
    .act(act), .abort_req(abort_req)
  );

  sweep_chan_state u_state (
    .clk(clk), .rst_n(rst_n), .open_edge(open_edge), .close_edge(close_edge),
    .act(act), .abort_req(abort_req),
    .ch_sel(ch_sel), .res_ch(res_ch), .res_valid(res_valid),
    .conv_abort(conv_abort)
  );
endmodule

// File: rtl/sweep_seq_chk.sv
module sweep_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic ch_sel,
  input logic res_ch,
  input logic res_valid,
  input logic conv_abort
);
  logic cs_prev, rise_w, fall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_prev <= 1'b1;
    else        cs_prev <= cs_n;
  end

  assign rise_w = cs_n & ~cs_prev;
  assign fall_w = ~cs_n & cs_prev;

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (!ch_sel && !res_ch && !res_valid && !conv_abort));

  assert_sel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_w |=> $stable(ch_sel));

  assert_tag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !cs_prev) |=> $stable({res_ch, res_valid}));

  assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(fall_w));

  assert_abort_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |=> !conv_abort);

  assert_abort_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_abort) |-> $past(rise_w));
endmodule

bind sweep_seq sweep_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ch_sel(ch_sel),
  .res_ch(res_ch), .res_valid(res_valid), .conv_abort(conv_abort)
);

// File: tb/tb_sweep_seq.sv
module tb_sweep_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, conv_done;
  logic ch_sel, res_ch, res_valid, conv_abort;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // bench model
  bit sel_m = 1'b0, pend_ch_m = 1'b0, pend_vld_m = 1'b0;
  bit tag_ch_m = 1'b0, tag_vld_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sweep_seq dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .conv_done(conv_done),
    .ch_sel(ch_sel), .res_ch(res_ch), .res_valid(res_valid),
    .conv_abort(conv_abort)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sclk_pulse();
    sclk = 1'b1; tick(); tick();
    sclk = 1'b0; tick(); tick();
  endtask

  task automatic done_pulse();
    conv_done = 1'b1; tick();
    conv_done = 1'b0; tick();
  endtask

  // One frame of n serial clocks; done pulse after clock done_at (<=0: none)
  task automatic run_frame(input int n, input int done_at, input string req);
    bit complete, home, abort_exp;
    cs_n = 1'b0; tick();
    chk(res_ch == tag_ch_m, "R7", "res_ch at frame start", res_ch, tag_ch_m);
    chk(res_valid == tag_vld_m, "R7", "res_valid at frame start",
        res_valid, tag_vld_m);
    for (int i = 1; i <= n; i++) begin
      sclk_pulse();
      if (i == done_at) done_pulse();
    end
    tick();
    chk(ch_sel == sel_m, "R6", "ch_sel before close", ch_sel, sel_m);
    cs_n = 1'b1; tick();
    complete  = (n >= 16) && (done_at >= 16) && (done_at <= n);
    home      = (n >= 4) && (n <= 7);
    abort_exp = !complete && (n >= 16);
    pend_ch_m  = sel_m;
    pend_vld_m = complete;
    if (complete)  sel_m = ~sel_m;
    else if (home) sel_m = 1'b0;
    chk(ch_sel == sel_m, req, "ch_sel after close", ch_sel, sel_m);
    chk(conv_abort == abort_exp, req, "conv_abort at close", conv_abort, abort_exp);
    tick();
    chk(conv_abort == 1'b0, "R9", "conv_abort one cycle later", conv_abort, 0);
    chk(ch_sel == sel_m, "R6", "ch_sel idle", ch_sel, sel_m);
    tick(); tick();
    tag_ch_m  = pend_ch_m;
    tag_vld_m = pend_vld_m;
  endtask

  task automatic t_reset();
    chk(ch_sel == 1'b0, "R1", "ch_sel after reset", ch_sel, 0);
    chk(res_ch == 1'b0, "R1", "res_ch after reset", res_ch, 0);
    chk(res_valid == 1'b0, "R1", "res_valid after reset", res_valid, 0);
    chk(conv_abort == 1'b0, "R1", "conv_abort after reset", conv_abort, 0);
  endtask

  task automatic t_toggle();
    run_frame(16, 16, "R2");
    run_frame(18, 17, "R2");
    run_frame(16, 16, "R2");
  endtask

  task automatic t_home();
    run_frame(5, -1, "R3");   // from 1 back to 0
    run_frame(16, 16, "R2");
    run_frame(4, -1, "R3");   // lower limit
    run_frame(16, 16, "R2");
    run_frame(7, -1, "R3");   // upper limit
    run_frame(16, 16, "R2");
  endtask

  task automatic t_hold();
    run_frame(3, -1, "R4");
    run_frame(0, -1, "R4");
    run_frame(8, -1, "R5");
    run_frame(20, -1, "R9");
  endtask

  task automatic t_ignore_done();
    run_frame(12, 6, "R8");   // done before 16th clock
    run_frame(20, 10, "R8");  // done early in a long frame
    done_pulse();             // done while idle
    run_frame(16, -1, "R8");
    run_frame(16, 16, "R2");
    run_frame(2, -1, "R7");
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; conv_done = 1'b0;
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick(); tick();
    t_reset();
    t_toggle();
    t_home();
    t_hold();
    t_ignore_done();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule